// File: doc/BRIEF.md
# Configurable External Interrupt Detector

This block turns a group of asynchronous interrupt pins into clean, clock-aligned interrupt requests for a downstream priority controller. Every pin is brought into the clock domain through two flops. A run-length filter then removes pulses that are too short. Finally, an edge or level detector matched to that pin's configured sensitivity produces the request. Edge events set a sticky pending flag, which holds until the consumer pulses that source's acknowledge bit. A level-sensed source instead shows its filtered pin state directly.

The pins fall into four classes:

- **Non-maskable input.** Senses falling edges unless told to sense rising ones.
- **One four-mode input.** Can sense a high level, a low level, a rising edge or a falling edge.
- **Edge-selectable inputs.** A group of these, each set to rising or falling.
- **Timer-side pairs.** In each pair, the first pin is edge-selectable and the second detects rising edges only. These pairs use a longer minimum pulse width, which itself has a normal setting and a slow setting.

A change of any source's sensitivity setting masks that source's detection for one cycle. This keeps a mode switch from being taken as an event.

Top module: `ext_irq_cond`

## Requirements
- R1: After reset every `pend_o` bit is 0, and every filtered pin level starts low.
- R2: A pin reaches the filter through a two-flop synchroniser. A qualified edge on an edge source shows on `pend_o` at the (3+W)-th rising clock edge after the pin changes. W is the qualification width, and with the default W=4 this is the 7th rising edge.
- R3: The non-maskable pin, the four-mode pin and the edge-selectable pins each need an active phase of at least FAST_W=4 clock cycles. A phase of 3 cycles or less is ignored.
- R4: Pair pins need an active phase of at least MID_W=8 cycles while `pair_slow_i`=0, and at least SLOW_W=128 cycles while `pair_slow_i`=1. Shorter phases are ignored.
- R5: Each edge source detects only the edge it is configured for:
  - The non-maskable pin senses falling edges when `nmi_rise_i`=0 and rising edges when it is 1.
  - An edge-selectable pin i senses falling edges when `esel_fall_i[i]`=1 and rising edges otherwise.
  - The first pin of pair j follows `pair_fall_i[j]` in the same way.
  - The second pin of each pair always senses rising edges.
- R6: `lvl_mode_i` selects the four-mode pin's sensitivity: 00 rising edge, 01 falling edge, 10 high level, 11 low level. In the two level modes, `pend_o[1]` equals the filtered pin level, or its inverse for low level. It is not latched, and `ack_i[1]` has no effect on it.
- R7: An edge source's pending bit stays set until `ack_i` for that source is high at a clock edge. That clears it, unless a new event arrives in the same cycle.
- R8: In the cycle in which a source's sensitivity setting differs from its value in the previous cycle, that source does not record an event.
- R9: `pend_o` bits are assigned as follows:
  - bit 0 is the non-maskable pin;
  - bit 1 is the four-mode pin;
  - bits 2 to 2+NUM_ESEL-1 are the edge-selectable pins, in order;
  - the pair pins follow, in `pair_pin_i` order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nmi_i | input | 1 | Non-maskable interrupt pin |
| lvl_pin_i | input | 1 | Four-mode interrupt pin |
| esel_pin_i | input | NUM_ESEL | Edge-selectable interrupt pins |
| pair_pin_i | input | 2*NUM_PAIR | Pair pins; even bit selectable, odd bit rising only |
| nmi_rise_i | input | 1 | 1: non-maskable pin senses rising edges |
| lvl_mode_i | input | 2 | Four-mode pin sensitivity code |
| esel_fall_i | input | NUM_ESEL | 1: pin senses falling edges |
| pair_fall_i | input | NUM_PAIR | 1: first pin of pair senses falling edges |
| pair_slow_i | input | 1 | 1: pair pins use the long qualification width |
| ack_i | input | NSRC | Per-source pending clear |
| pend_o | output | NSRC | Per-source request |

## Verification
A filter counter that is off by one shows up at the ports as a pulse exactly at the width limit being dropped, or one cycle short of it being taken. It also shifts the moment a request rises, by one cycle, relative to the fixed latency of 3+W rising edges. A wrong registered copy of the sensitivity setting shows as a lost or spurious request when the setting is switched in the very cycle a filtered edge lands. A mis-wired source index or sense mode shows up within one pulse as a wrong or missing bit in `pend_o`.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    SENSE_RISE = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_HIGH = 2'b10,
    SENSE_LOW  = 2'b11
  } sense_e;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/ext_irq_qual.sv
module ext_irq_qual #(
  parameter int unsigned W_LO = 4,
  parameter int unsigned W_HI = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic long_i,
  output logic flt_o
);
  localparam int unsigned CW = $clog2(W_HI + 1);
  localparam logic [CW-1:0] LIM_LO = CW'(W_LO - 1);
  localparam logic [CW-1:0] LIM_HI = CW'(W_HI - 1);

  logic [CW-1:0] cnt_q, lim;
  logic          flt_q;

  assign lim = long_i ? LIM_HI : LIM_LO;

  // filtered level moves only after W consecutive differing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      flt_q <= 1'b0;
    end else if (sync_i == flt_q) begin
      cnt_q <= '0;
    end else if (cnt_q >= lim) begin
      cnt_q <= '0;
      flt_q <= sync_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign flt_o = flt_q;
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       flt_i,
  input  logic       flt_d_i,
  input  logic [1:0] sense_i,
  input  logic       sup_i,
  input  logic       ack_i,
  output logic       pend_o
);
  logic lvl_en, rise, fall, hit, pend_q;

  assign lvl_en = sense_i[1];
  assign rise   = flt_i & ~flt_d_i;
  assign fall   = ~flt_i & flt_d_i;
  assign hit    = ~sup_i & ((sense_i == SENSE_RISE & rise) |
                            (sense_i == SENSE_FALL & fall));

  // new event wins over a same-cycle acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (lvl_en) pend_q <= 1'b0;
    else             pend_q <= (pend_q & ~ack_i) | hit;
  end

  assign pend_o = lvl_en ? (flt_i ^ sense_i[0]) : pend_q;
endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_ESEL = 4,
  parameter int unsigned NUM_PAIR = 2,
  parameter int unsigned FAST_W   = 4,
  parameter int unsigned MID_W    = 8,
  parameter int unsigned SLOW_W   = 128,
  localparam int unsigned IDX_PAIR = 2 + NUM_ESEL,
  localparam int unsigned NSRC     = IDX_PAIR + 2 * NUM_PAIR
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  nmi_i,
  input  logic                  lvl_pin_i,
  input  logic [NUM_ESEL-1:0]   esel_pin_i,
  input  logic [2*NUM_PAIR-1:0] pair_pin_i,
  input  logic                  nmi_rise_i,
  input  logic [1:0]            lvl_mode_i,
  input  logic [NUM_ESEL-1:0]   esel_fall_i,
  input  logic [NUM_PAIR-1:0]   pair_fall_i,
  input  logic                  pair_slow_i,
  input  logic [NSRC-1:0]       ack_i,
  output logic [NSRC-1:0]       pend_o
);
  logic [NSRC-1:0]       pin_raw, sync_s, flt_s, flt_d_q;
  logic [NSRC-1:0][1:0]  sense_s, sense_q;

  assign pin_raw = {pair_pin_i, esel_pin_i, lvl_pin_i, nmi_i};

  always_comb begin
    sense_s[0] = nmi_rise_i ? SENSE_RISE : SENSE_FALL;
    sense_s[1] = lvl_mode_i;
    for (int i = 0; i < NUM_ESEL; i++)
      sense_s[2+i] = esel_fall_i[i] ? SENSE_FALL : SENSE_RISE;
    for (int j = 0; j < NUM_PAIR; j++) begin
      sense_s[IDX_PAIR+2*j]   = pair_fall_i[j] ? SENSE_FALL : SENSE_RISE;
      sense_s[IDX_PAIR+2*j+1] = SENSE_RISE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sense_q <= '0;
      flt_d_q <= '0;
    end else begin
      sense_q <= sense_s;
      flt_d_q <= flt_s;
    end
  end

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    localparam bit          IS_PAIR = (k >= IDX_PAIR);
    localparam int unsigned QLO     = IS_PAIR ? MID_W  : FAST_W;
    localparam int unsigned QHI     = IS_PAIR ? SLOW_W : FAST_W;

    logic long_sel;
    assign long_sel = IS_PAIR & pair_slow_i;

    ext_irq_sync u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pin_raw[k]),
      .q_o   (sync_s[k])
    );

    ext_irq_qual #(.W_LO(QLO), .W_HI(QHI)) u_qual (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .sync_i(sync_s[k]),
      .long_i(long_sel),
      .flt_o (flt_s[k])
    );

    ext_irq_detect u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .flt_i  (flt_s[k]),
      .flt_d_i(flt_d_q[k]),
      .sense_i(sense_s[k]),
      .sup_i  (sense_s[k] != sense_q[k]),
      .ack_i  (ack_i[k]),
      .pend_o (pend_o[k])
    );
  end
endmodule

// File: rtl/ext_irq_cond_chk.sv
module ext_irq_cond_chk #(
  parameter int unsigned NSRC     = 10,
  parameter int unsigned IDX_PAIR = 6,
  parameter int unsigned FAST_W   = 4,
  parameter int unsigned MID_W    = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NSRC-1:0]      sync_i,
  input logic [NSRC-1:0]      flt_i,
  input logic [NSRC-1:0]      flt_d_i,
  input logic [NSRC-1:0][1:0] sense_i,
  input logic [NSRC-1:0]      ack_i,
  input logic [NSRC-1:0]      pend_o
);
  for (genvar k = 0; k < NSRC; k++) begin : g_chk
    localparam int unsigned MINW = (k >= IDX_PAIR) ? MID_W : FAST_W;
    logic [7:0] run_q;
    logic       last_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        run_q  <= '0;
        last_q <= 1'b0;
      end else begin
        last_q <= sync_i[k];
        if (sync_i[k] != last_q) run_q <= 8'd1;
        else if (run_q != 8'hff) run_q <= run_q + 8'd1;
      end
    end

    // R3 / R4: filter output moves only after a long enough stable run
    a_r3_min_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flt_i[k] != $past(flt_i[k])) |-> (run_q >= 8'(MINW) && last_q == flt_i[k]));

    // R7: held until acknowledged
    a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_o[k] && !ack_i[k] && !sense_i[k][1]) |=> (pend_o[k] || sense_i[k][1]));

    // R7: acknowledge without new event clears
    a_r7_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i[k] && flt_i[k] == flt_d_i[k] && !sense_i[k][1]) |=> (!pend_o[k] || sense_i[k][1]));

    // R5: an edge request only rises after a filtered transition
    a_r5_set_needs_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(pend_o[k]) && !sense_i[k][1]) |-> $past(flt_i[k] != flt_d_i[k]));
  end
endmodule

bind ext_irq_cond ext_irq_cond_chk #(
  .NSRC(NSRC), .IDX_PAIR(IDX_PAIR), .FAST_W(FAST_W), .MID_W(MID_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .sync_i (sync_s),
  .flt_i  (flt_s),
  .flt_d_i(flt_d_q),
  .sense_i(sense_s),
  .ack_i  (ack_i),
  .pend_o (pend_o)
);

// File: tb/ext_irq_cond_bench.sv
module ext_irq_cond_bench;
  localparam int NUM_ESEL = 4;
  localparam int NUM_PAIR = 2;
  localparam int FAST_W   = 4;
  localparam int MID_W    = 8;
  localparam int SLOW_W   = 128;
  localparam int IDX_PAIR = 2 + NUM_ESEL;
  localparam int NSRC     = IDX_PAIR + 2 * NUM_PAIR;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  nmi, lvl_pin;
  logic [NUM_ESEL-1:0]   esel_pin, esel_fall;
  logic [2*NUM_PAIR-1:0] pair_pin;
  logic [NUM_PAIR-1:0]   pair_fall;
  logic                  nmi_rise, pair_slow;
  logic [1:0]            lvl_mode;
  logic [NSRC-1:0]       ack, pend;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ext_irq_cond u_ext_irq_cond (
    .clk_i(clk), .rst_ni(rst_n), .nmi_i(nmi), .lvl_pin_i(lvl_pin),
    .esel_pin_i(esel_pin), .pair_pin_i(pair_pin), .nmi_rise_i(nmi_rise),
    .lvl_mode_i(lvl_mode), .esel_fall_i(esel_fall), .pair_fall_i(pair_fall),
    .pair_slow_i(pair_slow), .ack_i(ack), .pend_o(pend)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int thr(int k, bit slow);
    if (k < IDX_PAIR) return FAST_W;
    return slow ? SLOW_W : MID_W;
  endfunction

  function automatic bit can_fall(int k);
    if (k < IDX_PAIR) return 1'b1;
    return ((k - IDX_PAIR) % 2) == 0;
  endfunction

  task automatic set_pin(int k, logic v);
    if (k == 0)             nmi = v;
    else if (k == 1)        lvl_pin = v;
    else if (k < IDX_PAIR)  esel_pin[k-2] = v;
    else                    pair_pin[k-IDX_PAIR] = v;
  endtask

  task automatic set_fall(int k, bit f);
    if (k == 0)             nmi_rise = ~f;
    else if (k == 1)        lvl_mode = f ? 2'b01 : 2'b00;
    else if (k < IDX_PAIR)  esel_fall[k-2] = f;
    else if (can_fall(k))   pair_fall[(k-IDX_PAIR)/2] = f;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_all();
    @(negedge clk);
    nmi = 0; lvl_pin = 0; esel_pin = '0; pair_pin = '0;
    nmi_rise = 1; lvl_mode = 2'b00; esel_fall = '0; pair_fall = '0;
    pair_slow = 0; ack = '0;
  endtask

  task automatic ack_all();
    @(negedge clk) ack = '1;
    @(negedge clk) ack = '0;
  endtask

  // R3 R4 R5 R7 R9: pulse one source and compare the whole request vector
  task automatic run_pulse(int k, bit fall, bit slow, int w);
    logic [NSRC-1:0] exp;
    idle_all();
    pair_slow = slow;
    set_fall(k, fall);
    set_pin(k, fall);
    settle(SLOW_W + 10);
    ack_all();
    settle(2);
    chk(pend == '0, "R5 idle no request", int'(pend), 0);
    @(negedge clk) set_pin(k, ~fall);
    repeat (w) @(negedge clk);
    set_pin(k, fall);
    settle(SLOW_W + 10);
    exp = (w >= thr(k, slow)) ? (NSRC'(1) << k) : '0;
    chk(pend == exp, $sformatf("R3/R4/R9 src %0d w %0d fall %0d slow %0d", k, w, fall, slow),
        int'(pend), int'(exp));
    if (exp != '0) begin
      ack_all();
      chk(pend == '0, "R7 ack clears", int'(pend), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    nmi = 0; lvl_pin = 0; esel_pin = '0; pair_pin = '0;
    nmi_rise = 1; lvl_mode = 2'b00; esel_fall = '0; pair_fall = '0;
    pair_slow = 0; ack = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(pend == '0, "R1 reset state", int'(pend), 0);

    // R2 exact latency on first edge-selectable pin, rising
    idle_all(); settle(10);
    @(negedge clk) esel_pin[0] = 1;
    repeat (2 + FAST_W) @(posedge clk);
    @(negedge clk) chk(pend[2] == 0, "R2 not before 3+W", int'(pend[2]), 0);
    @(posedge clk);
    @(negedge clk) chk(pend[2] == 1, "R2 at 3+W", int'(pend[2]), 1);
    chk(pend[1:0] == 2'b00, "R9 only own bit", int'(pend[1:0]), 0);
    @(negedge clk) chk(pend[2] == 1, "R7 held without ack", int'(pend[2]), 1);
    ack_all();
    chk(pend[2] == 0, "R7 ack clears", int'(pend[2]), 0);

    // R8: switch fall->rise in the cycle the filtered edge lands: no event
    idle_all(); esel_fall[0] = 1; settle(10); ack_all();
    @(negedge clk) esel_pin[0] = 1;
    repeat (2 + FAST_W) @(posedge clk);
    @(negedge clk) esel_fall[0] = 0;
    settle(6);
    chk(pend[2] == 0, "R8 suppressed on change", int'(pend[2]), 0);
    // control: switch one cycle earlier, edge counts
    idle_all(); esel_fall[0] = 1; settle(10); ack_all();
    @(negedge clk) esel_pin[0] = 1;
    repeat (1 + FAST_W) @(posedge clk);
    @(negedge clk) esel_fall[0] = 0;
    settle(6);
    chk(pend[2] == 1, "R8 one cycle earlier detects", int'(pend[2]), 1);

    // directed width boundaries
    run_pulse(0, 1, 0, FAST_W - 1);   // R3 NMI falling default, too short
    run_pulse(0, 1, 0, FAST_W);       // R5 NMI falling
    run_pulse(0, 0, 0, FAST_W);       // R5 NMI rising
    run_pulse(1, 1, 0, FAST_W);       // R6 edge falling mode
    run_pulse(1, 0, 0, FAST_W - 1);
    run_pulse(IDX_PAIR, 0, 0, MID_W - 1);   // R4
    run_pulse(IDX_PAIR, 0, 0, MID_W);
    run_pulse(IDX_PAIR + 1, 0, 1, SLOW_W - 1);
    run_pulse(IDX_PAIR + 1, 0, 1, SLOW_W);

    // R5 rising-only pair member ignores the fall select of its pair
    idle_all(); pair_fall = '1; settle(10); ack_all();
    @(negedge clk) pair_pin[1] = 1;
    settle(MID_W + 2);
    pair_pin[1] = 0;
    settle(MID_W + 6);
    chk(pend == (NSRC'(1) << (IDX_PAIR + 1)), "R5 rising-only member", int'(pend),
        1 << (IDX_PAIR + 1));

    // R6 level modes
    idle_all(); lvl_mode = 2'b10; settle(10);
    chk(pend[1] == 0, "R6 high level, pin low", int'(pend[1]), 0);
    lvl_pin = 1; settle(FAST_W + 4);
    chk(pend[1] == 1, "R6 high level, pin high", int'(pend[1]), 1);
    ack_all();
    chk(pend[1] == 1, "R6 ack no effect", int'(pend[1]), 1);
    lvl_pin = 0; settle(FAST_W + 4);
    chk(pend[1] == 0, "R6 not latched", int'(pend[1]), 0);
    lvl_mode = 2'b11; settle(2);
    chk(pend[1] == 1, "R6 low level, pin low", int'(pend[1]), 1);

    // constrained random
    void'($urandom(32'h5eed_0042));
    for (int it = 0; it < 40; it++) begin
      int k, w;
      bit f, s;
      k = int'($urandom_range(NSRC - 1, 0));
      f = can_fall(k) ? bit'($urandom_range(1, 0)) : 1'b0;
      s = (k >= IDX_PAIR) ? bit'($urandom_range(1, 0)) : 1'b0;
      w = thr(k, s) + int'($urandom_range(4, 0)) - 2;
      run_pulse(k, f, s, w);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule